// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. The frame shape is picked at run time by a small set of format inputs: a 7- or 8-bit character, an optional parity bit of either sense, one or two stop bits, and a multiprocessor mode in which an address/data marker goes out in the slot after the character.

Software, or a neighbouring bus block, writes a byte through a strobe into a one-deep holding buffer. While the transmit enable is high, the buffer is handed to a shift register as soon as the line is free. A bit-rate tick of one clock cycle comes from outside, and each serial bit lasts sixteen of these ticks. The format inputs are sampled when a frame begins, so they can be rewritten while a frame is on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line `txd` is high, `busy` is 0 and `buf_empty` is 1.
- R2: A frame is one low start bit, then the character least significant bit first, then the optional ninth-slot bit, then the stop bit or bits, which are high. Each bit holds the line for exactly 16 `tick` pulses, and the line is high whenever no frame is being sent.
- R3: With `fmt_len8` = 0 the frame carries data bits 0..6. With `fmt_len8` = 1 it carries bits 0..7.
- R4: With `fmt_par_en` = 1 and `fmt_mp_mode` = 0, a parity bit follows the character. For `fmt_par_odd` = 0 the number of ones in the sent character bits plus the parity bit is even. For `fmt_par_odd` = 1 it is odd. With `fmt_par_en` = 0, `fmt_par_odd` has no effect and no parity bit is sent.
- R5: `fmt_stop2` = 0 sends one stop bit and `fmt_stop2` = 1 sends two. A frame therefore lasts 16 × (1 + data bits + slot bit + stop bits) ticks.
- R6: With `fmt_mp_mode` = 1 the slot after the character carries `fmt_addr` (1 = address frame, 0 = data frame). This bit takes the place of the parity bit, whatever `fmt_par_en` is set to.
- R7: While `tx_en` = 0 no frame starts, and a byte that has been written stays in the buffer (`buf_empty` = 0).
- R8: Clearing `tx_en` during a frame lets that frame finish in full. The line then stays idle even if the buffer holds a byte.
- R9: The format inputs and the data are captured in the cycle the frame starts. Changes made later do not alter that frame.
- R10: A write strobe is accepted when the buffer is empty, or in the same cycle that the buffer is handed to the shifter. A strobe arriving while the buffer is full and not being handed over is ignored.
- R11: `busy` rises in the cycle after the buffer is handed over, with the start bit already on `txd`. It falls after the last stop bit's sixteenth tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-rate enable, one cycle wide |
| fmt_len8 | input | 1 | 1 = 8-bit character, 0 = 7-bit |
| fmt_par_en | input | 1 | 1 = send a parity bit |
| fmt_par_odd | input | 1 | 1 = odd parity, 0 = even |
| fmt_stop2 | input | 1 | 1 = two stop bits |
| fmt_mp_mode | input | 1 | 1 = send the address/data marker in the slot bit |
| fmt_addr | input | 1 | Marker value: 1 = address frame, 0 = data frame |
| tx_en | input | 1 | Transmit enable |
| wr_data | input | 8 | Character to send |
| wr_stb | input | 1 | Write strobe for `wr_data` |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | A frame is on the line |
| buf_empty | output | 1 | The holding buffer can take a byte |

## Verification
A new byte can be written in the very cycle the held byte moves into the shifter. The bench forces this by holding a byte with `tx_en` low, then raising `tx_en` and pulsing `wr_stb` at the same edge. One cycle later `busy` must be high and `buf_empty` low, and the second character must follow the first on the line. A second overlap is a format change while a frame is being sent. In both cases the behavioural frame queue in the bench, compared with `txd` on every cycle, decides whether the right bits left in the right order.

// File: rtl/uft_pkg.sv
package uft_pkg;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
    logic stop2;
    logic mp_mode;
    logic addr;
  } uft_fmt_t;

  function automatic int uft_data_bits(uft_fmt_t f);
    return f.len8 ? DATA_W : DATA_W - 1;
  endfunction

  function automatic logic uft_has_slot(uft_fmt_t f);
    return f.par_en | f.mp_mode;
  endfunction

  function automatic logic [CNT_W-1:0] uft_frame_bits(uft_fmt_t f);
    int n;
    n = 1 + uft_data_bits(f) + (uft_has_slot(f) ? 1 : 0) + (f.stop2 ? 2 : 1);
    return CNT_W'(n);
  endfunction

  // Marker in multiprocessor mode, otherwise parity over the sent bits
  function automatic logic uft_slot_bit(uft_fmt_t f, logic [DATA_W-1:0] d);
    logic acc;
    acc = f.par_odd;
    for (int i = 0; i < DATA_W; i++)
      if (i < uft_data_bits(f)) acc = acc ^ d[i];
    return f.mp_mode ? f.addr : acc;
  endfunction

  // Frame laid out LSB first: start, data, slot, stop ones (padding is ones)
  function automatic logic [FRAME_W-1:0] uft_build_frame(uft_fmt_t f, logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] v;
    int nd;
    nd = uft_data_bits(f);
    for (int i = 0; i < FRAME_W; i++) begin
      if (i == 0)
        v[i] = 1'b0;
      else if (i <= nd)
        v[i] = d[i-1];
      else if (i == nd + 1 && uft_has_slot(f))
        v[i] = uft_slot_bit(f, d);
      else
        v[i] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_done
);
  localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt;

  assign bit_done = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      cnt <= '0;
    else if (tick)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/uft_holdbuf.sv
module uft_holdbuf
  import uft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic load;
  assign load = wr_stb && (!full || take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (load) begin
        data <= wr_data;
        full <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uft_shifter.sv
module uft_shifter
  import uft_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   len_in,
  input  logic               bit_done,
  output logic               active,
  output logic               line
);
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;

  assign line = active ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sh     <= '1;
      left   <= '0;
    end else if (start) begin
      active <= 1'b1;
      sh     <= frame_in;
      left   <= len_in;
    end else if (active && bit_done) begin
      sh   <= {1'b1, sh[FRAME_W-1:1]};
      left <= left - 1'b1;
      if (left == CNT_W'(1))
        active <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fmt_len8,
  input  logic              fmt_par_en,
  input  logic              fmt_par_odd,
  input  logic              fmt_stop2,
  input  logic              fmt_mp_mode,
  input  logic              fmt_addr,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_stb,
  output logic              txd,
  output logic              busy,
  output logic              buf_empty
);
  uft_fmt_t           fmt;
  logic               hb_full;
  logic [DATA_W-1:0]  hb_data;
  logic               active;
  logic               take;
  logic               bit_done;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   frame_len;

  assign fmt = '{len8: fmt_len8, par_en: fmt_par_en, par_odd: fmt_par_odd,
                 stop2: fmt_stop2, mp_mode: fmt_mp_mode, addr: fmt_addr};

  assign take      = hb_full && tx_en && !active;
  assign frame     = uft_build_frame(fmt, hb_data);
  assign frame_len = uft_frame_bits(fmt);

  uft_holdbuf u_buf (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .take(take), .full(hb_full), .data(hb_data)
  );

  uft_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(active), .tick(tick), .bit_done(bit_done)
  );

  uft_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(take), .frame_in(frame),
    .len_in(frame_len), .bit_done(bit_done), .active(active), .line(txd)
  );

  assign busy      = active;
  assign buf_empty = !hb_full;
endmodule

// File: rtl/uft_tx_checker.sv
module uft_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_stb,
  input logic txd,
  input logic busy,
  input logic buf_empty,
  input logic take,
  input logic bit_done
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  a_r2_hold_between_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_done) |=> $stable(txd));
  a_r5_last_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));
  a_r7_no_take_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !take);
  a_r10_take_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !buf_empty);
  a_r10_write_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && buf_empty) |=> !buf_empty);
  a_r11_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);
endmodule

bind uart_frame_tx uft_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb), .txd(txd),
  .busy(busy), .buf_empty(buf_empty), .take(take), .bit_done(bit_done)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic f_len8 = 0, f_par_en = 0, f_par_odd = 0, f_stop2 = 0, f_mp = 0, f_addr = 0;
  logic tx_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic wr_stb = 0;
  logic txd, busy, buf_empty;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy_ticks = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .fmt_len8(f_len8), .fmt_par_en(f_par_en), .fmt_par_odd(f_par_odd),
    .fmt_stop2(f_stop2), .fmt_mp_mode(f_mp), .fmt_addr(f_addr),
    .tx_en(tx_en), .wr_data(wr_data), .wr_stb(wr_stb),
    .txd(txd), .busy(busy), .buf_empty(buf_empty)
  );

  // tick on every second cycle
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick <= (cyc % 2 == 1);
  end

  always @(posedge clk) if (busy && tick) busy_ticks <= busy_ticks + 1;

  // behavioural reference: queue of line levels, one entry per serial bit
  bit   m_full, m_active;
  bit   m_q[$];
  int   m_tc;
  logic [7:0] m_data;
  bit   m_take;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_full = 0; m_active = 0; m_tc = 0; m_q.delete(); m_data = 0;
    end else begin
      m_take = m_full && tx_en && !m_active;
      if (m_active && tick) begin
        m_tc++;
        if (m_tc == 16) begin
          m_tc = 0;
          void'(m_q.pop_front());
          if (m_q.size() == 0) m_active = 0;
        end
      end
      if (m_take) begin
        int nd;
        bit ones;
        nd = f_len8 ? 8 : 7;
        ones = 0;
        m_q.push_back(1'b0);
        for (int i = 0; i < nd; i++) begin
          m_q.push_back(m_data[i]);
          ones ^= m_data[i];
        end
        if (f_mp) m_q.push_back(f_addr);
        else if (f_par_en) m_q.push_back(ones ^ f_par_odd);
        m_q.push_back(1'b1);
        if (f_stop2) m_q.push_back(1'b1);
        m_active = 1; m_tc = 0;
      end
      if (wr_stb && (!m_full || m_take)) begin
        m_data = wr_data; m_full = 1;
      end else if (m_take) m_full = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cur_req, "txd",       txd,       m_active ? int'(m_q[0]) : 1);
    check(cur_req, "busy",      busy,      m_active);
    check(cur_req, "buf_empty", buf_empty, !m_full);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [7:0] d);
    wr_data = d; wr_stb = 1; step(1); wr_stb = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((busy || !buf_empty) && guard < 5000) begin step(1); guard++; end
  endtask

  task automatic send(string req, bit l8, bit pe, bit po, bit s2, bit mp, bit ad,
                      logic [7:0] d, int bits);
    cur_req = req;
    f_len8 = l8; f_par_en = pe; f_par_odd = po; f_stop2 = s2; f_mp = mp; f_addr = ad;
    tx_en = 1;
    busy_ticks = 0;
    write(d);
    wait_idle();
    check(req, "frame length in ticks", busy_ticks, bits * 16);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    check("R1", "reset txd", txd, 1);
    check("R1", "reset busy", busy, 0);
    check("R1", "reset buf_empty", buf_empty, 1);

    // R7: disabled transmitter keeps the byte
    cur_req = "R7";
    write(8'h5A);
    step(100);
    check("R7", "busy while disabled", busy, 0);
    check("R7", "buf_empty while disabled", buf_empty, 0);
    tx_en = 1;
    wait_idle();

    send("R2", 0, 0, 0, 0, 0, 0, 8'hA5, 9);
    send("R3", 0, 0, 0, 0, 0, 0, 8'hFF, 9);
    send("R3", 1, 0, 0, 0, 0, 0, 8'h3C, 10);
    send("R4", 1, 1, 0, 0, 0, 0, 8'h07, 11);
    send("R4", 0, 1, 1, 0, 0, 0, 8'h55, 10);
    send("R4", 1, 0, 1, 0, 0, 0, 8'h81, 10);
    send("R5", 1, 1, 0, 1, 0, 0, 8'hC3, 12);
    send("R5", 0, 0, 0, 1, 0, 0, 8'h12, 10);
    send("R6", 1, 1, 0, 0, 1, 1, 8'h9E, 11);
    send("R6", 0, 0, 0, 1, 1, 0, 8'h6B, 11);

    // R9: format rewritten mid-frame
    cur_req = "R9";
    f_len8 = 0; f_par_en = 0; f_stop2 = 0; f_mp = 0;
    busy_ticks = 0;
    write(8'hE7);
    step(60);
    f_len8 = 1; f_par_en = 1; f_stop2 = 1;
    wait_idle();
    check("R9", "frame keeps start-time format", busy_ticks, 9 * 16);

    // R10: write in the cycle of hand-over, then write while full
    cur_req = "R10";
    tx_en = 0;
    write(8'h11);
    tx_en = 1; wr_data = 8'h22; wr_stb = 1;
    step(1);
    wr_stb = 0;
    check("R10", "busy after hand-over", busy, 1);
    check("R11", "start bit on line", txd, 0);
    check("R10", "second byte held", buf_empty, 0);
    write(8'h33);
    wait_idle();

    // R8: disable mid-frame with a byte waiting
    cur_req = "R8";
    write(8'h44);
    write(8'h66);
    step(50);
    tx_en = 0;
    busy_ticks = 0;
    step(700);
    check("R8", "line idle after frame", busy, 0);
    check("R8", "txd idle", txd, 1);
    check("R8", "byte still waiting", buf_empty, 0);
    tx_en = 1;
    wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule